// File: doc/BRIEF.md
# Media Command Stream Header Decoder

The decoder sits on a stream of 32-bit command dwords bound for a small media microcontroller engine. Every command opens with a header dword. The decoder tests three header fields to decide whether the command belongs to this engine. It reads a seven-bit sub-command code, and it uses a biased length field to find where the following command begins. The header dword is always consumed and never passed on.

For a command that belongs to this engine and carries a known sub-command code, the decoder forwards each body dword. Each forwarded dword carries the sub-command code as a tag, its position within the body, and markers for the first and the final body dword. The decoder consumes the body of a header from another engine, or of an unknown sub-command, without forwarding it, and raises a one-cycle event flag. If the length field of a known command differs from the size that the command kind should have, the decoder raises a size event but still obeys the length field. The start command's first body dword also drives a last-object indication taken from its bit 0.

The input and the output both use valid/ready handshakes. The output is a combinational view of the input, so the input stalls whenever a forwarded dword meets back-pressure.

Top module: `vcmd_parser`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0, `in_ready` is 1 and all three event flags are 0.
- R2: A header belongs to this engine only when bits 31:29 equal 3, bits 28:27 equal 2 and bits 26:23 equal 11. For any other header, `ev_foreign` pulses for one cycle, in the cycle after the header is accepted, and none of the command's body dwords are forwarded.
- R3: The header's bits 11:0 hold the length L, and the command occupies L+2 dwords in total. After the header, exactly L+1 body dwords are consumed, and the dword that follows is treated as a new header.
- R4: The known sub-command codes, taken from bits 22:16, are 0, 1, 2, 3, 4, 5, 32 and 33. Each body dword of a known own-engine command appears on `out_data` with `out_tag` equal to the code.
- R5: An own-engine header whose sub-command code is not known pulses `ev_unknown` in the cycle after acceptance, and its body is consumed without being forwarded.
- R6: The expected total sizes are 3, 5, 6, 2, 49, 11, 5 and 2 dwords for codes 0, 1, 2, 3, 4, 5, 32 and 33. If L+2 differs from the expected size, `ev_size_err` pulses in the cycle after acceptance, and the body is still forwarded using L.
- R7: `out_idx` is 1 on the first body dword and increases by one on each body dword after it. `out_first` is high only on index 1, and `out_last` is high only on the final body dword.
- R8: While a forwarded dword has `out_ready` low, `in_ready` is low. No dword is dropped or repeated.
- R9: The header dword and the body dwords that are not forwarded are accepted whatever the value of `out_ready`.
- R10: `out_last_obj` equals bit 0 of the first body dword of a sub-command 33 command while that dword is presented, and is 0 at all other times.
- R11: `out_valid` is high only while a body dword of a known own-engine command is on the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input dword valid |
| in_data | input | 32 | Input command dword |
| in_ready | output | 1 | Input dword accepted when high with in_valid |
| out_valid | output | 1 | Forwarded body dword valid |
| out_ready | input | 1 | Downstream accepts the forwarded dword |
| out_data | output | 32 | Forwarded body dword |
| out_tag | output | 7 | Sub-command code of the current command |
| out_idx | output | 13 | Body dword index, starting at 1 |
| out_first | output | 1 | First body dword |
| out_last | output | 1 | Final body dword |
| out_last_obj | output | 1 | Last-object bit of the start command |
| ev_foreign | output | 1 | Pulse: header of another engine |
| ev_unknown | output | 1 | Pulse: own-engine header with unknown sub-command |
| ev_size_err | output | 1 | Pulse: length disagrees with expected size |

## Verification
The bench builds command streams and compares every cycle against a model of them. The streams include the 49-dword address table command, length-zero commands whose body is a single dword, and commands that sit just beside an own-engine match (one field off). A decoder that reads the length without its bias of two would drift out of step, take a body dword for a header, and from then on report spurious events and wrong tags. Random back-pressure, arriving both on forwarded bodies and on skipped bodies, exposes two faults: a ready path that loses or repeats dwords, and one that stalls on dwords that are never forwarded. Start commands with bit 0 set and with bit 0 clear, together with size mismatches whose body must still be forwarded, expose a last-object bit read from the wrong dword and a size check that cuts the command short.

// File: rtl/vcmd_pkg.sv
`timescale 1ns/1ps
package vcmd_pkg;
  // Header field positions, fixed by the command format.
  localparam int LEN_LSB  = 0;
  localparam int SUB_LSB  = 16;
  localparam int OPC_LSB  = 23;
  localparam int PIPE_LSB = 27;
  localparam int CTYP_LSB = 29;

  localparam logic [2:0] OWN_CTYP = 3'd3;
  localparam logic [1:0] OWN_PIPE = 2'd2;
  localparam logic [3:0] OWN_OPC  = 4'd11;

  typedef enum logic [6:0] {
    SC_MODE   = 7'd0,
    SC_ILOAD  = 7'd1,
    SC_DLOAD  = 7'd2,
    SC_CFG    = 7'd3,
    SC_VATBL  = 7'd4,
    SC_INDOBJ = 7'd5,
    SC_STREAM = 7'd32,
    SC_START  = 7'd33
  } subcmd_e;

  // Expected total command size in dwords; zero marks an unknown code.
  function automatic logic [7:0] sub_total(input logic [6:0] sub);
    case (sub)
      SC_MODE:   sub_total = 8'd3;
      SC_ILOAD:  sub_total = 8'd5;
      SC_DLOAD:  sub_total = 8'd6;
      SC_CFG:    sub_total = 8'd2;
      SC_VATBL:  sub_total = 8'd49;
      SC_INDOBJ: sub_total = 8'd11;
      SC_STREAM: sub_total = 8'd5;
      SC_START:  sub_total = 8'd2;
      default:   sub_total = 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/vcmd_hdr_classify.sv
`timescale 1ns/1ps
module vcmd_hdr_classify
  import vcmd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 12,
  parameter int SUB_W  = 7
) (
  input  logic [DATA_W-1:0] hdr,
  output logic              is_own,
  output logic              is_known,
  output logic              size_bad,
  output logic [SUB_W-1:0]  sub,
  output logic [LEN_W-1:0]  len
);
  localparam int TOT_W = LEN_W + 1;

  logic [7:0]       exp_tot;
  logic [TOT_W-1:0] got_tot;

  always_comb begin
    sub      = hdr[SUB_LSB +: SUB_W];
    len      = hdr[LEN_LSB +: LEN_W];
    is_own   = (hdr[CTYP_LSB +: 3] == OWN_CTYP) &&
               (hdr[PIPE_LSB +: 2] == OWN_PIPE) &&
               (hdr[OPC_LSB  +: 4] == OWN_OPC);
    exp_tot  = sub_total(sub);
    is_known = (exp_tot != 8'd0);
    got_tot  = {1'b0, len} + TOT_W'(2);
    size_bad = is_known && (got_tot != TOT_W'(exp_tot));
  end
endmodule

// File: rtl/vcmd_frame_track.sv
`timescale 1ns/1ps
module vcmd_frame_track #(
  parameter int LEN_W = 12,
  parameter int SUB_W = 7,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_take,
  input  logic             body_take,
  input  logic             fwd_in,
  input  logic [SUB_W-1:0] sub_in,
  input  logic [LEN_W-1:0] len_in,
  output logic             in_body,
  output logic             fwd,
  output logic [SUB_W-1:0] tag,
  output logic [CNT_W-1:0] idx,
  output logic             final_dw
);
  logic             body_q, body_n;
  logic             fwd_q, fwd_n;
  logic [SUB_W-1:0] tag_q, tag_n;
  logic [CNT_W-1:0] idx_q, idx_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic             adv;

  assign adv = hdr_take | body_take;

  always_comb begin
    body_n = body_q;
    fwd_n  = fwd_q;
    tag_n  = tag_q;
    idx_n  = idx_q;
    rem_n  = rem_q;
    if (hdr_take) begin
      body_n = 1'b1;
      fwd_n  = fwd_in;
      tag_n  = sub_in;
      idx_n  = CNT_W'(1);
      rem_n  = {1'b0, len_in} + CNT_W'(1);
    end else if (body_take) begin
      idx_n = idx_q + CNT_W'(1);
      rem_n = rem_q - CNT_W'(1);
      if (rem_q == CNT_W'(1)) body_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      body_q <= 1'b0;
      fwd_q  <= 1'b0;
      tag_q  <= '0;
      idx_q  <= '0;
      rem_q  <= '0;
    end else if (adv) begin
      body_q <= body_n;
      fwd_q  <= fwd_n;
      tag_q  <= tag_n;
      idx_q  <= idx_n;
      rem_q  <= rem_n;
    end
  end

  assign in_body  = body_q;
  assign fwd      = fwd_q;
  assign tag      = tag_q;
  assign idx      = idx_q;
  assign final_dw = (rem_q == CNT_W'(1));
endmodule

// File: rtl/vcmd_parser.sv
`timescale 1ns/1ps
module vcmd_parser
  import vcmd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 12,
  parameter int SUB_W  = 7,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [SUB_W-1:0]  out_tag,
  output logic [CNT_W-1:0]  out_idx,
  output logic              out_first,
  output logic              out_last,
  output logic              out_last_obj,
  output logic              ev_foreign,
  output logic              ev_unknown,
  output logic              ev_size_err
);
  logic             is_own, is_known, size_bad;
  logic [SUB_W-1:0] hdr_sub;
  logic [LEN_W-1:0] hdr_len;
  logic             in_body, fwd, final_dw;
  logic [SUB_W-1:0] tag;
  logic [CNT_W-1:0] idx;
  logic             hdr_take, body_take;
  logic             foreign_n, unknown_n, size_n;
  logic             foreign_q, unknown_q, size_q;

  vcmd_hdr_classify #(.DATA_W(DATA_W), .LEN_W(LEN_W), .SUB_W(SUB_W)) u_cls (
    .hdr      (in_data),
    .is_own   (is_own),
    .is_known (is_known),
    .size_bad (size_bad),
    .sub      (hdr_sub),
    .len      (hdr_len)
  );

  assign hdr_take  = in_valid && !in_body;
  assign body_take = in_valid && in_body && in_ready;

  vcmd_frame_track #(.LEN_W(LEN_W), .SUB_W(SUB_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_take  (hdr_take),
    .body_take (body_take),
    .fwd_in    (is_own && is_known),
    .sub_in    (hdr_sub),
    .len_in    (hdr_len),
    .in_body   (in_body),
    .fwd       (fwd),
    .tag       (tag),
    .idx       (idx),
    .final_dw  (final_dw)
  );

  // Header and skipped body dwords never wait; forwarded ones follow the sink.
  assign in_ready  = !in_body || !fwd || out_ready;
  assign out_valid = in_valid && in_body && fwd;
  assign out_data  = in_data;
  assign out_tag   = tag;
  assign out_idx   = idx;
  assign out_first = (idx == CNT_W'(1));
  assign out_last  = final_dw;
  assign out_last_obj = out_valid && (tag == SUB_W'(SC_START)) &&
                        (idx == CNT_W'(1)) && in_data[0];

  always_comb begin
    foreign_n = hdr_take && !is_own;
    unknown_n = hdr_take && is_own && !is_known;
    size_n    = hdr_take && is_own && size_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreign_q <= 1'b0;
      unknown_q <= 1'b0;
      size_q    <= 1'b0;
    end else begin
      foreign_q <= foreign_n;
      unknown_q <= unknown_n;
      size_q    <= size_n;
    end
  end

  assign ev_foreign  = foreign_q;
  assign ev_unknown  = unknown_q;
  assign ev_size_err = size_q;
endmodule

// File: rtl/vcmd_parser_chk.sv
`timescale 1ns/1ps
module vcmd_parser_chk #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 12,
  parameter int SUB_W  = 7,
  localparam int CNT_W = LEN_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [SUB_W-1:0]  out_tag,
  input logic [CNT_W-1:0]  out_idx,
  input logic              out_first,
  input logic              out_last,
  input logic              out_last_obj,
  input logic              ev_foreign,
  input logic              ev_unknown,
  input logic              ev_size_err
);
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_hold_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_idx));

  p_skip_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !out_valid) |-> in_ready);

  p_events_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_foreign, ev_unknown, ev_size_err}));

  p_foreign_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_foreign |-> !out_valid);

  p_unknown_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unknown |-> !out_valid);

  p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (out_idx == $past(out_idx) + CNT_W'(1)) && !out_first);

  p_last_obj_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_last_obj |-> (out_valid && out_first && out_tag == SUB_W'(33) && in_data[0]));
endmodule

bind vcmd_parser vcmd_parser_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W), .SUB_W(SUB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_tag(out_tag), .out_idx(out_idx), .out_first(out_first),
  .out_last(out_last), .out_last_obj(out_last_obj), .ev_foreign(ev_foreign),
  .ev_unknown(ev_unknown), .ev_size_err(ev_size_err)
);

// File: tb/sim_vcmd_parser.sv
`timescale 1ns/1ps
module sim_vcmd_parser;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic [6:0]  out_tag;
  logic [12:0] out_idx;
  logic        out_first, out_last, out_last_obj;
  logic        ev_foreign, ev_unknown, ev_size_err;

  always #2.5 clk = ~clk;

  vcmd_parser u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_tag(out_tag), .out_idx(out_idx),
    .out_first(out_first), .out_last(out_last), .out_last_obj(out_last_obj),
    .ev_foreign(ev_foreign), .ev_unknown(ev_unknown), .ev_size_err(ev_size_err)
  );

  typedef struct packed {
    logic [31:0] d;
    logic [6:0]  tag;
    logic [12:0] idx;
    logic        first;
    logic        last;
    logic        lobj;
  } exp_t;

  logic [31:0] sdat[$];
  bit          sfwd[$];
  exp_t        eq[$];
  int          evq[$];
  int          checks = 0;
  int          errors = 0;

  function automatic int exp_total(input int sub);
    case (sub)
      0: return 3;   1: return 5;   2: return 6;   3: return 2;
      4: return 49;  5: return 11;  32: return 5;  33: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Append one command to the stream and its expected results (R2..R6, R10).
  task automatic add_cmd(input int ct, input int pt, input int op, input int sub,
                         input int len, input int lobj_bit);
    logic [31:0] h, b;
    bit own, known;
    h = {ct[2:0], pt[1:0], op[3:0], sub[6:0], 4'b0, len[11:0]};
    own   = (ct == 3) && (pt == 2) && (op == 11);
    known = exp_total(sub) != 0;
    sdat.push_back(h); sfwd.push_back(1'b0);
    if (!own) evq.push_back(1);
    else if (!known) evq.push_back(2);
    else if (len + 2 != exp_total(sub)) evq.push_back(3);
    for (int i = 1; i <= len + 1; i++) begin
      exp_t e;
      b = $urandom;
      if (i == 1 && lobj_bit >= 0) b[0] = lobj_bit[0];
      sdat.push_back(b); sfwd.push_back(own && known);
      if (own && known) begin
        e.d = b; e.tag = sub[6:0]; e.idx = 13'(i);
        e.first = (i == 1); e.last = (i == len + 1);
        e.lobj = (sub == 33) && (i == 1) && b[0];
        eq.push_back(e);
      end
    end
  endtask

  initial begin
    int pos, wd, k, sub, len, ct, pt, op, code, ev;
    exp_t e;
    void'($urandom(32'h1bad5eed));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk({ev_foreign, ev_unknown, ev_size_err} == 3'b0, "R1", "events in reset",
        {ev_foreign, ev_unknown, ev_size_err}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "idle after reset",
        {in_ready, out_valid}, 2'b10);

    // Directed corner cases
    add_cmd(3, 2, 11, 0, 1, -1);
    add_cmd(3, 2, 11, 1, 3, -1);
    add_cmd(3, 2, 11, 2, 4, -1);
    add_cmd(3, 2, 11, 3, 0, -1);
    add_cmd(3, 2, 11, 4, 47, -1);
    add_cmd(3, 2, 11, 5, 9, -1);
    add_cmd(3, 2, 11, 32, 3, -1);
    add_cmd(3, 2, 11, 33, 0, 1);
    add_cmd(3, 2, 11, 33, 0, 0);
    add_cmd(3, 2, 11, 2, 7, -1);
    add_cmd(3, 2, 11, 33, 2, 1);
    add_cmd(2, 2, 11, 0, 3, -1);
    add_cmd(3, 1, 11, 0, 3, -1);
    add_cmd(3, 2, 10, 0, 3, -1);
    add_cmd(3, 2, 11, 6, 2, -1);
    add_cmd(3, 2, 11, 127, 0, -1);
    // Random mix
    for (int n = 0; n < 120; n++) begin
      k = $urandom_range(0, 99);
      if (k < 65) begin
        code = $urandom_range(0, 7);
        sub = (code < 6) ? code : 26 + code;
        len = ($urandom_range(0, 9) < 7) ? exp_total(sub) - 2 : $urandom_range(0, 20);
        add_cmd(3, 2, 11, sub, len, $urandom_range(0, 1));
      end else if (k < 82) begin
        do sub = $urandom_range(0, 127); while (exp_total(sub) != 0);
        add_cmd(3, 2, 11, sub, $urandom_range(0, 12), -1);
      end else begin
        do begin
          ct = $urandom_range(0, 7); pt = $urandom_range(0, 3); op = $urandom_range(0, 15);
        end while (ct == 3 && pt == 2 && op == 11);
        add_cmd(ct, pt, op, $urandom_range(0, 127), $urandom_range(0, 12), -1);
      end
    end

    pos = 0; wd = 0;
    while (pos < sdat.size()) begin
      @(posedge clk); #1;
      out_ready = ($urandom_range(0, 3) != 0);
      in_valid  = ($urandom_range(0, 4) != 0);
      in_data   = sdat[pos];
      @(negedge clk);
      chk(out_valid == (in_valid && sfwd[pos]), "R11", "out_valid", out_valid,
          in_valid && sfwd[pos]);
      if (in_valid)
        chk(in_ready == (sfwd[pos] ? out_ready : 1'b1), sfwd[pos] ? "R8" : "R9",
            "in_ready", in_ready, sfwd[pos] ? out_ready : 1'b1);
      if (out_valid && out_ready) begin
        if (eq.size() == 0) chk(1'b0, "R3", "extra output dword", out_data, 0);
        else begin
          e = eq.pop_front();
          chk(out_data == e.d && out_tag == e.tag, "R4", "data/tag",
              {out_data, out_tag}, {e.d, e.tag});
          chk(out_idx == e.idx && out_first == e.first && out_last == e.last, "R7",
              "idx/first/last", {out_idx, out_first, out_last}, {e.idx, e.first, e.last});
          chk(out_last_obj == e.lobj, "R10", "last_obj", out_last_obj, e.lobj);
        end
      end else if (!out_valid) begin
        chk(out_last_obj == 1'b0, "R10", "last_obj idle", out_last_obj, 0);
      end
      ev = ev_foreign ? 1 : ev_unknown ? 2 : ev_size_err ? 3 : 0;
      if (ev != 0) begin
        if (evq.size() == 0) chk(1'b0, "R2", "unexpected event", ev, 0);
        else begin
          code = evq.pop_front();
          chk(ev == code, code == 1 ? "R2" : code == 2 ? "R5" : "R6", "event kind", ev, code);
        end
      end
      if (in_valid && in_ready) pos++;
      wd++;
      if (wd > 100000) begin
        chk(1'b0, "R3", "watchdog expired", pos, sdat.size());
        break;
      end
    end
    @(posedge clk); #1 in_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      ev = ev_foreign ? 1 : ev_unknown ? 2 : ev_size_err ? 3 : 0;
      if (ev != 0 && evq.size() != 0) begin
        code = evq.pop_front();
        chk(ev == code, code == 1 ? "R2" : code == 2 ? "R5" : "R6", "tail event", ev, code);
      end
    end
    chk(eq.size() == 0, "R3", "output dwords left over", eq.size(), 0);
    chk(evq.size() == 0, "R6", "events left over", evq.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule